// File: doc/BRIEF.md
# Out-of-Order Issue Scoreboard

This block is the hazard-tracking controller of a small dynamically scheduled core. Decoded instructions arrive one at a time, in program order. Each one carries an operation class, a destination register and two source registers. The block holds one status slot per functional unit and a pending-writer table indexed by architectural register. From these it decides three things: when the instruction at the head of the stream may issue, when each unit may fetch its operands, and when each unit may retire its result into the register file.

Each instruction passes through four steps: issue, operand read, execute and write result. Issue stalls on a busy unit (structural) and on a destination that already has an in-flight writer (WAW). The operand read waits until neither source has an uncompleted earlier producer (RAW). Registers are read only in the operand-read step, so a writeback is held back while an older instruction still needs the old value of its destination (WAR). Execution and completion run out of order, and no renaming is needed. The functional units, the register file data and instruction fetch lie outside the block. The units report completion through one-cycle done pulses.

Top module: `sb_scoreboard`

## Requirements
- R1: After reset every unit is free and no register has a pending writer. With no request, all grant outputs are low, and the first valid instruction is granted issue at once.
- R2: Class code k always maps to unit k. A valid instruction whose unit holds an instruction is not granted issue, including in that unit's writeback cycle. It is granted in the cycle after the writeback.
- R3: A valid instruction whose destination has an in-flight writer is not granted issue. It is granted in the cycle after that writer's writeback.
- R4: If the producer of a source register writes back in the same cycle that the consumer issues, that source counts as ready. The consumer's operand read is then granted in the next cycle.
- R5: A unit whose source has an earlier in-flight producer gets no operand-read grant. The grant comes in the cycle after that producer's writeback.
- R6: With both sources free of pending writers, the operand-read grant rd_grant[k] of unit k is high in the cycle after issue. It is high for exactly one cycle per instruction.
- R7: A done pulse counts only once the unit has read its operands. A pulse while the unit is free or waiting to read is ignored and leads to no writeback.
- R8: After a counted done pulse, wb_grant[k] is high in the next cycle unless a WAR conflict exists. That writeback frees both the unit and its destination register, so an instruction using either can issue in the following cycle.
- R9: A unit's writeback is withheld while another unit is waiting to read and has the same register as a source that is ready but not yet read. It is released in the cycle after that reader's operand-read grant.
- R10: Units complete in any order. A later instruction may write back before an earlier one, and several units may write back in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | A decoded instruction is presented |
| iss_class | input | FU_W | Operation class, which is also the unit index |
| iss_dst | input | REG_W | Destination register |
| iss_src_a | input | REG_W | First source register |
| iss_src_b | input | REG_W | Second source register |
| exec_done | input | NUM_FU | Per-unit execution-complete pulse |
| iss_grant | output | 1 | Presented instruction issues this cycle |
| rd_grant | output | NUM_FU | Unit k reads its operands this cycle |
| wb_grant | output | NUM_FU | Unit k writes its result this cycle |

## Verification
The stream is fed cycle by cycle, and each cycle's full grant vector is compared against values worked out by hand. The patterns used are:
- an independent instruction, to fix the base four-step latency;
- back-to-back instructions of one class, to separate the structural stall from the WAW stall;
- a consumer of an in-flight destination, to separate a RAW wait from a plain read;
- a consumer issued in its producer's writeback cycle, which shows whether writeback status is forwarded into issue;
- a stalled reader that sources a later instruction's destination, which shows whether the WAR hold releases at the right cycle.

Early done pulses and completions that are reversed or simultaneous show whether done is gated by the unit's step and whether completion is independent across units.

// File: rtl/sb_pkg.sv
package sb_pkg;

   // Step of the instruction held by one functional unit.
   typedef enum logic [1:0] {
      FU_IDLE  = 2'd0,
      FU_READ  = 2'd1,
      FU_EXEC  = 2'd2,
      FU_WRITE = 2'd3
   } fu_state_e;

endpackage

// File: rtl/sb_result_table.sv
// Pending-writer table: one flag and one owning unit per architectural register.
module sb_result_table #(
   parameter int NUM_FU  = 4,
   parameter int NUM_REG = 32,
   parameter int FU_W    = 2,
   parameter int REG_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              claim_en,
   input  logic [REG_W-1:0]  claim_reg,
   input  logic [FU_W-1:0]   claim_fu,
   input  logic [NUM_FU-1:0] wb_grant,
   input  logic [REG_W-1:0]  look_dst,
   input  logic [REG_W-1:0]  look_a,
   input  logic [REG_W-1:0]  look_b,
   output logic              dst_pending,
   output logic              a_pending,
   output logic [FU_W-1:0]   a_owner,
   output logic              b_pending,
   output logic [FU_W-1:0]   b_owner
);

   logic [NUM_REG-1:0]           pend;
   logic [NUM_REG-1:0][FU_W-1:0] owner;

   for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
      logic            pend_q;
      logic [FU_W-1:0] own_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            own_q  <= '0;
         end else if (claim_en && claim_reg == REG_W'(r)) begin
            pend_q <= 1'b1;
            own_q  <= claim_fu;
         end else if (pend_q && wb_grant[own_q]) begin
            pend_q <= 1'b0;
         end
      end

      assign pend[r]  = pend_q;
      assign owner[r] = own_q;
   end

   assign dst_pending = pend[look_dst];
   assign a_pending   = pend[look_a];
   assign a_owner     = owner[look_a];
   assign b_pending   = pend[look_b];
   assign b_owner     = owner[look_b];

endmodule

// File: rtl/sb_fu_slot.sv
// Status slot of one functional unit: registers, producer tags, ready flags, step.
module sb_fu_slot #(
   parameter int NUM_FU = 4,
   parameter int FU_W   = 2,
   parameter int REG_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  logic [REG_W-1:0]   new_dst,
   input  logic [REG_W-1:0]   new_a,
   input  logic [REG_W-1:0]   new_b,
   input  logic               a_pend,
   input  logic [FU_W-1:0]    a_own,
   input  logic               b_pend,
   input  logic [FU_W-1:0]    b_own,
   input  logic [NUM_FU-1:0]  wb_grant,
   input  logic               done,
   input  logic               self_wb,
   output sb_pkg::fu_state_e  state,
   output logic [REG_W-1:0]   dst,
   output logic [REG_W-1:0]   src_a,
   output logic [REG_W-1:0]   src_b,
   output logic               rdy_a,
   output logic               rdy_b,
   output logic               read_go
);

   logic [FU_W-1:0] tag_a, tag_b;

   assign read_go = (state == sb_pkg::FU_READ) && rdy_a && rdy_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= sb_pkg::FU_IDLE;
         dst   <= '0;
         src_a <= '0;
         src_b <= '0;
         tag_a <= '0;
         tag_b <= '0;
         rdy_a <= 1'b0;
         rdy_b <= 1'b0;
      end else begin
         case (state)
            sb_pkg::FU_IDLE: begin
               if (take) begin
                  state <= sb_pkg::FU_READ;
                  dst   <= new_dst;
                  src_a <= new_a;
                  src_b <= new_b;
                  tag_a <= a_own;
                  tag_b <= b_own;
                  // a producer retiring in this very cycle counts as done
                  rdy_a <= !a_pend || wb_grant[a_own];
                  rdy_b <= !b_pend || wb_grant[b_own];
               end
            end
            sb_pkg::FU_READ: begin
               if (!rdy_a && wb_grant[tag_a]) rdy_a <= 1'b1;
               if (!rdy_b && wb_grant[tag_b]) rdy_b <= 1'b1;
               if (read_go) state <= sb_pkg::FU_EXEC;
            end
            sb_pkg::FU_EXEC: begin
               if (done) state <= sb_pkg::FU_WRITE;
            end
            default: begin
               if (self_wb) state <= sb_pkg::FU_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/sb_war_gate.sv
// Writeback permission: a unit waiting to write is held while an older unit
// still has to read the old value of that register.
module sb_war_gate #(
   parameter int NUM_FU = 4,
   parameter int REG_W  = 5
) (
   input  sb_pkg::fu_state_e [NUM_FU-1:0] st,
   input  logic [NUM_FU-1:0][REG_W-1:0]  dst,
   input  logic [NUM_FU-1:0][REG_W-1:0]  src_a,
   input  logic [NUM_FU-1:0][REG_W-1:0]  src_b,
   input  logic [NUM_FU-1:0]             rdy_a,
   input  logic [NUM_FU-1:0]             rdy_b,
   output logic [NUM_FU-1:0]             wb_ok
);

   always_comb begin
      for (int w = 0; w < NUM_FU; w++) begin
         wb_ok[w] = (st[w] == sb_pkg::FU_WRITE);
         for (int f = 0; f < NUM_FU; f++) begin
            if (f != w && st[f] == sb_pkg::FU_READ &&
                ((src_a[f] == dst[w] && rdy_a[f]) ||
                 (src_b[f] == dst[w] && rdy_b[f])))
               wb_ok[w] = 1'b0;
         end
      end
   end

endmodule

// File: rtl/sb_scoreboard.sv
// Centralized scoreboard: in-order issue, out-of-order read/execute/write.
module sb_scoreboard #(
   parameter int  NUM_FU  = 4,
   parameter int  NUM_REG = 32,
   localparam int FU_W    = $clog2(NUM_FU),
   localparam int REG_W   = $clog2(NUM_REG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [FU_W-1:0]   iss_class,
   input  logic [REG_W-1:0]  iss_dst,
   input  logic [REG_W-1:0]  iss_src_a,
   input  logic [REG_W-1:0]  iss_src_b,
   input  logic [NUM_FU-1:0] exec_done,
   output logic              iss_grant,
   output logic [NUM_FU-1:0] rd_grant,
   output logic [NUM_FU-1:0] wb_grant
);

   // every class code must name a unit and every register code a register
   if (NUM_FU < 2 || (1 << FU_W) != NUM_FU) begin : g_bad_fu
      $error("sb_scoreboard: NUM_FU must be a power of two, at least 2");
   end
   if (NUM_REG < 2 || (1 << REG_W) != NUM_REG) begin : g_bad_reg
      $error("sb_scoreboard: NUM_REG must be a power of two, at least 2");
   end

   sb_pkg::fu_state_e [NUM_FU-1:0] st;
   logic [NUM_FU-1:0][REG_W-1:0]  u_dst, u_a, u_b;
   logic [NUM_FU-1:0]             u_rdy_a, u_rdy_b, take, read_go, wb_ok;
   logic                          dst_pend, a_pend, b_pend;
   logic [FU_W-1:0]               a_own, b_own;

   sb_result_table #(
      .NUM_FU (NUM_FU),
      .NUM_REG(NUM_REG),
      .FU_W   (FU_W),
      .REG_W  (REG_W)
   ) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .claim_en   (iss_grant),
      .claim_reg  (iss_dst),
      .claim_fu   (iss_class),
      .wb_grant   (wb_ok),
      .look_dst   (iss_dst),
      .look_a     (iss_src_a),
      .look_b     (iss_src_b),
      .dst_pending(dst_pend),
      .a_pending  (a_pend),
      .a_owner    (a_own),
      .b_pending  (b_pend),
      .b_owner    (b_own)
   );

   // structural and WAW checks; the pending flag of the destination is still
   // set during its writer's writeback cycle, so issue waits one more cycle
   assign iss_grant = iss_valid && (st[iss_class] == sb_pkg::FU_IDLE) && !dst_pend;

   for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
      assign take[u] = iss_grant && (iss_class == FU_W'(u));

      sb_fu_slot #(
         .NUM_FU(NUM_FU),
         .FU_W  (FU_W),
         .REG_W (REG_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .take    (take[u]),
         .new_dst (iss_dst),
         .new_a   (iss_src_a),
         .new_b   (iss_src_b),
         .a_pend  (a_pend),
         .a_own   (a_own),
         .b_pend  (b_pend),
         .b_own   (b_own),
         .wb_grant(wb_ok),
         .done    (exec_done[u]),
         .self_wb (wb_ok[u]),
         .state   (st[u]),
         .dst     (u_dst[u]),
         .src_a   (u_a[u]),
         .src_b   (u_b[u]),
         .rdy_a   (u_rdy_a[u]),
         .rdy_b   (u_rdy_b[u]),
         .read_go (read_go[u])
      );
   end

   sb_war_gate #(
      .NUM_FU(NUM_FU),
      .REG_W (REG_W)
   ) u_war (
      .st   (st),
      .dst  (u_dst),
      .src_a(u_a),
      .src_b(u_b),
      .rdy_a(u_rdy_a),
      .rdy_b(u_rdy_b),
      .wb_ok(wb_ok)
   );

   assign rd_grant = read_go;
   assign wb_grant = wb_ok;

endmodule

// File: rtl/sb_scoreboard_chk.sv
// Temporal checks on the scoreboard's grant outputs.
module sb_scoreboard_chk #(
   parameter int NUM_FU = 4,
   parameter int FU_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              iss_grant,
   input logic [FU_W-1:0]   iss_class,
   input logic [NUM_FU-1:0] rd_grant,
   input logic [NUM_FU-1:0] wb_grant
);

   assert_grants_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({iss_grant, rd_grant, wb_grant}));

   // a unit that just took an instruction is busy in the next cycle
   assert_no_reissue_R2: assert property (@(posedge clk) disable iff (!rst_n)
      iss_grant |=> !(iss_grant && iss_class == $past(iss_class)));

   for (genvar u = 0; u < NUM_FU; u++) begin : g_chk
      assert_read_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
         rd_grant[u] |=> !rd_grant[u]);

      assert_write_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
         wb_grant[u] |=> !wb_grant[u]);

      // operands must be read and done counted before any writeback
      assert_no_early_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (iss_grant && iss_class == FU_W'(u)) |=> !wb_grant[u]);
   end

endmodule

bind sb_scoreboard sb_scoreboard_chk #(
   .NUM_FU(NUM_FU),
   .FU_W  (FU_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .iss_grant(iss_grant),
   .iss_class(iss_class),
   .rd_grant (rd_grant),
   .wb_grant (wb_grant)
);

// File: tb/sb_scoreboard_test.sv
module sb_scoreboard_test;

   localparam int NFU = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           iss_valid = 1'b0;
   logic [1:0]     iss_class = '0;
   logic [4:0]     iss_dst = '0;
   logic [4:0]     iss_src_a = '0;
   logic [4:0]     iss_src_b = '0;
   logic [NFU-1:0] exec_done = '0;
   logic           iss_grant;
   logic [NFU-1:0] rd_grant;
   logic [NFU-1:0] wb_grant;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit ended   = 1'b0;

   // expected grant vector per cycle: {iss, rd[3:0], wb[3:0]}
   int         q_cyc[$];
   logic [8:0] q_g[$];
   string      q_req[$];

   sb_scoreboard uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .iss_valid(iss_valid),
      .iss_class(iss_class),
      .iss_dst  (iss_dst),
      .iss_src_a(iss_src_a),
      .iss_src_b(iss_src_b),
      .exec_done(exec_done),
      .iss_grant(iss_grant),
      .rd_grant (rd_grant),
      .wb_grant (wb_grant)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // driver: applies one cycle of stimulus and pushes the expected grants
   task automatic step(input logic iv, input int cls, input int d, input int sa,
                       input int sb, input logic [3:0] dn, input logic ei,
                       input logic [3:0] erd, input logic [3:0] ewb, input string req);
      @(negedge clk);
      iss_valid = iv;
      iss_class = cls[1:0];
      iss_dst   = d[4:0];
      iss_src_a = sa[4:0];
      iss_src_b = sb[4:0];
      exec_done = dn;
      q_cyc.push_back(cyc);
      q_g.push_back({ei, erd, ewb});
      q_req.push_back(req);
   endtask

   task automatic idle(input logic [3:0] dn, input logic [3:0] erd,
                       input logic [3:0] ewb, input string req);
      step(1'b0, 0, 0, 0, 0, dn, 1'b0, erd, ewb, req);
   endtask

   // monitor: pops one expected item per driven cycle and compares
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (q_g.size() > 0) begin
            automatic int         ec = q_cyc.pop_front();
            automatic logic [8:0] eg = q_g.pop_front();
            automatic string      er = q_req.pop_front();
            automatic logic [8:0] og = {iss_grant, rd_grant, wb_grant};
            n_tests++;
            if (ec != cyc || og !== eg) begin
               n_fail++;
               $display("FAIL %s cycle %0d: grants %b expected %b", er, cyc, og, eg);
            end
         end
      end
   end

   initial begin
      #(20 * 5000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: quiet after reset, first instruction issues immediately
      idle(4'b0000, 4'b0000, 4'b0000, "R1");
      step(1, 0, 1, 2, 3, 4'b0000, 1, 4'b0000, 4'b0000, "R1");
      idle(4'b0000, 4'b0001, 4'b0000, "R6");
      idle(4'b0000, 4'b0000, 4'b0000, "R6");
      idle(4'b0001, 4'b0000, 4'b0000, "R8");
      idle(4'b0000, 4'b0000, 4'b0001, "R8");
      step(1, 0, 1, 2, 3, 4'b0000, 1, 4'b0000, 4'b0000, "R8");
      idle(4'b0000, 4'b0001, 4'b0000, "R6");
      idle(4'b0001, 4'b0000, 4'b0000, "R8");
      idle(4'b0000, 4'b0000, 4'b0001, "R8");

      // R2: structural stall on unit 1
      step(1, 1, 4, 5, 6, 4'b0000, 1, 4'b0000, 4'b0000, "R2");
      step(1, 1, 7, 0, 0, 4'b0000, 0, 4'b0010, 4'b0000, "R2");
      step(1, 1, 7, 0, 0, 4'b0010, 0, 4'b0000, 4'b0000, "R2");
      step(1, 1, 7, 0, 0, 4'b0000, 0, 4'b0000, 4'b0010, "R2");
      step(1, 1, 7, 0, 0, 4'b0000, 1, 4'b0000, 4'b0000, "R2");
      idle(4'b0000, 4'b0010, 4'b0000, "R6");
      idle(4'b0010, 4'b0000, 4'b0000, "R8");
      idle(4'b0000, 4'b0000, 4'b0010, "R8");

      // R3: WAW on r10 across units 2 and 3; R5: RAW on r10 by unit 0
      step(1, 2, 10, 1, 2, 4'b0000, 1, 4'b0000, 4'b0000, "R3");
      step(1, 3, 10, 3, 4, 4'b0000, 0, 4'b0100, 4'b0000, "R3");
      step(1, 3, 10, 3, 4, 4'b0100, 0, 4'b0000, 4'b0000, "R3");
      step(1, 3, 10, 3, 4, 4'b0000, 0, 4'b0000, 4'b0100, "R3");
      step(1, 3, 10, 3, 4, 4'b0000, 1, 4'b0000, 4'b0000, "R3");
      step(1, 0, 11, 10, 5, 4'b0000, 1, 4'b1000, 4'b0000, "R5");
      idle(4'b1000, 4'b0000, 4'b0000, "R5");
      idle(4'b0000, 4'b0000, 4'b1000, "R5");
      idle(4'b0000, 4'b0001, 4'b0000, "R5");
      idle(4'b0001, 4'b0000, 4'b0000, "R8");
      idle(4'b0000, 4'b0000, 4'b0001, "R8");

      // R4: consumer issues in its producer's writeback cycle
      step(1, 1, 12, 0, 0, 4'b0000, 1, 4'b0000, 4'b0000, "R4");
      idle(4'b0000, 4'b0010, 4'b0000, "R4");
      idle(4'b0010, 4'b0000, 4'b0000, "R4");
      step(1, 2, 13, 12, 0, 4'b0000, 1, 4'b0000, 4'b0010, "R4");
      idle(4'b0000, 4'b0100, 4'b0000, "R4");
      idle(4'b0100, 4'b0000, 4'b0000, "R8");
      idle(4'b0000, 4'b0000, 4'b0100, "R8");

      // R7: done pulses while free and while waiting to read are ignored
      step(1, 3, 14, 0, 0, 4'b1000, 1, 4'b0000, 4'b0000, "R7");
      idle(4'b1000, 4'b1000, 4'b0000, "R7");
      idle(4'b0000, 4'b0000, 4'b0000, "R7");
      idle(4'b1000, 4'b0000, 4'b0000, "R7");
      idle(4'b0000, 4'b0000, 4'b1000, "R7");

      // R9: unit 2 writes r24, unit 1 reads r24 but waits on r20 from unit 0
      step(1, 0, 20, 21, 22, 4'b0000, 1, 4'b0000, 4'b0000, "R9");
      step(1, 1, 23, 24, 20, 4'b0000, 1, 4'b0001, 4'b0000, "R9");
      step(1, 2, 24, 0, 0, 4'b0000, 1, 4'b0000, 4'b0000, "R9");
      idle(4'b0000, 4'b0100, 4'b0000, "R9");
      idle(4'b0100, 4'b0000, 4'b0000, "R9");
      idle(4'b0000, 4'b0000, 4'b0000, "R9");
      idle(4'b0001, 4'b0000, 4'b0000, "R9");
      idle(4'b0000, 4'b0000, 4'b0001, "R9");
      idle(4'b0000, 4'b0010, 4'b0000, "R9");
      idle(4'b0000, 4'b0000, 4'b0100, "R9");
      idle(4'b0010, 4'b0000, 4'b0000, "R9");
      idle(4'b0000, 4'b0000, 4'b0010, "R9");

      // R10: later instruction completes first, then simultaneous writebacks
      step(1, 0, 2, 0, 0, 4'b0000, 1, 4'b0000, 4'b0000, "R10");
      step(1, 1, 3, 0, 0, 4'b0000, 1, 4'b0001, 4'b0000, "R10");
      idle(4'b0000, 4'b0010, 4'b0000, "R10");
      idle(4'b0010, 4'b0000, 4'b0000, "R10");
      idle(4'b0000, 4'b0000, 4'b0010, "R10");
      idle(4'b0001, 4'b0000, 4'b0000, "R10");
      idle(4'b0000, 4'b0000, 4'b0001, "R10");
      step(1, 2, 5, 0, 0, 4'b0000, 1, 4'b0000, 4'b0000, "R10");
      step(1, 3, 6, 0, 0, 4'b0000, 1, 4'b0100, 4'b0000, "R10");
      idle(4'b0000, 4'b1000, 4'b0000, "R10");
      idle(4'b1100, 4'b0000, 4'b0000, "R10");
      idle(4'b0000, 4'b0000, 4'b1100, "R10");

      @(negedge clk);
      exec_done = '0;
      #5;
      if (q_g.size() != 0) begin
         n_tests++;
         n_fail++;
         $display("FAIL R1 queue: %0d items left expected 0", q_g.size());
      end
      finish_run();
   end

endmodule